// File: doc/BRIEF.md
# Dual Status-LED Blink Controller

This block drives two indicator LEDs, a power LED and a suspend LED, from one 8-bit configuration byte. Each LED is governed by a 3-bit code that holds the pin low, releases it, or makes it a 50% duty square wave at 1 Hz, 1/2 Hz or 1/4 Hz. Each LED has a level output and an output-enable, so the pin can be used as an open-drain driver: the driver sinks current while the level is 0 and floats while the level is 1.

The top bit of the byte picks the source of the two codes. When it is clear, the codes come from a fixed policy driven by the system sleep-state input. When it is set, the two 3-bit fields of the byte are used directly. All three blink rates are taken from one shared counter that advances on an external half-second tick. Two LEDs that blink at the same rate therefore always switch together.

Top module: `dual_led_blinker`

## Requirements
- R1: After reset the configuration byte is 0x00 and the shared blink counter is 0, so the hardware policy is in force.
- R2: Code 000 drives the LED low (level 0, output-enable 1). Codes 001, 010 and 011 behave in the same way.
- R3: Code 111 releases the LED (level 1, output-enable 0).
- R4: Code 110 blinks at 1 Hz. The level equals bit 0 of the count of half-second ticks since reset and changes on the clock edge that samples each tick.
- R5: Code 101 follows bit 1 of that count (1/2 Hz) and code 100 follows bit 2 (1/4 Hz), both at 50% duty.
- R6: A write (cfg_wr high for one cycle) loads cfg_wdata. Bit 7 = 1 selects the programmed codes and bit 7 = 0 selects the hardware policy. The programmed power code is bits 6:4 and the programmed suspend code is bits 2:0. The new setting shows at the outputs from the clock edge that samples the write.
- R7: Under the hardware policy the power LED uses code 000 when sleep_state = 00 (S0), code 110 when sleep_state = 01 (S3), and code 111 when sleep_state is 10 or 11 (S5).
- R8: Under the hardware policy the suspend LED uses code 000 when sleep_state = 01 and code 111 for every other state.
- R9: When both LEDs use the same blinking code, their levels are equal in every cycle.
- R10: Bit 3 of the written byte has no effect on either LED.
- R11: led_level[1] and led_oe[1] belong to the power LED, and led_level[0] and led_oe[0] belong to the suspend LED. For each LED, led_oe is always the inverse of led_level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte to load |
| sleep_state | input | 2 | System state: 00 S0, 01 S3, 10/11 S5 |
| half_sec_tick | input | 1 | One-cycle pulse every half second |
| led_level | output | 2 | Pin level: bit 1 power LED, bit 0 suspend LED |
| led_oe | output | 2 | Output-enable per LED; 1 means the pin is sinking |

## Verification
A wrong blink counter shows up at the first tick that follows the error. A blinking LED then lands in the wrong phase, and two LEDs on the same code, or on related rates, stop lining up. A stale or mis-routed configuration bit shows one cycle after the write: an LED sits at the wrong fixed level, or ignores the sleep-state input when it should follow it. Each stimulus step is checked in the cycle after it is applied, so a fault is seen within one clock of being triggered.

// File: rtl/dlb_pkg.sv
`timescale 1ns/1ps
package dlb_pkg;

   // System sleep states as seen on the sleep_state input
   typedef enum logic [1:0] {
      SLP_ON      = 2'b00,
      SLP_SUSPEND = 2'b01,
      SLP_OFF     = 2'b10,
      SLP_OFF_ALT = 2'b11
   } sleep_state_e;

   localparam int STATE_W  = 2;
   localparam int CFG_W    = 8;
   localparam int LED_CNT  = 2;
   localparam int LED_PWR  = 1;
   localparam int LED_SUS  = 0;

endpackage

// File: rtl/dlb_phase_gen.sv
`timescale 1ns/1ps
module dlb_phase_gen #(
   parameter int PH_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   output logic [PH_W-1:0] phase
);

   generate
      if (PH_W < 1) begin : g_bad_width
         $error("dlb_phase_gen: PH_W must be at least 1");
      end
   endgenerate

   // Shared divider chain: bit r toggles every 2**r ticks
   always_ff @(posedge clk) begin
      if (!rst_n)
         phase <= '0;
      else if (tick)
         phase <= phase + PH_W'(1);
   end

   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(phase)); // R4
   AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (phase[0] != $past(phase[0]))); // R4

endmodule

// File: rtl/dlb_code_decode.sv
`timescale 1ns/1ps
module dlb_code_decode #(
   parameter int CODE_W = 3,
   parameter int PH_W   = 3
) (
   input  logic [CODE_W-1:0] code,
   input  logic [PH_W-1:0]   phase,
   output logic              level
);

   localparam logic [CODE_W-1:0] CODE_REL = '1;
   localparam int FASTEST   = (2**CODE_W) - 2;
   localparam int NUM_RATES = (2**(CODE_W-1)) - 1;

   generate
      if (PH_W < NUM_RATES) begin : g_bad_phase
         $error("dlb_code_decode: phase counter narrower than rate table");
      end
   endgenerate

   // Codes with the top bit set step down from the fastest rate;
   // all-ones releases the pin; everything else sinks.
   always_comb begin
      level = 1'b0;
      if (code == CODE_REL)
         level = 1'b1;
      for (int r = 0; r < NUM_RATES; r++) begin
         if (code == CODE_W'(FASTEST - r))
            level = phase[r];
      end
   end

endmodule

// File: rtl/dlb_hw_policy.sv
`timescale 1ns/1ps
module dlb_hw_policy
   import dlb_pkg::*;
#(
   parameter int CODE_W   = 3,
   parameter bit IS_POWER = 1'b0
) (
   input  logic [STATE_W-1:0] state,
   output logic [CODE_W-1:0]  code
);

   localparam logic [CODE_W-1:0] C_ON    = '0;
   localparam logic [CODE_W-1:0] C_OFF   = '1;
   localparam logic [CODE_W-1:0] C_BLINK = CODE_W'((2**CODE_W) - 2);

   generate
      if (IS_POWER) begin : g_power
         always_comb begin
            case (sleep_state_e'(state))
               SLP_ON:      code = C_ON;
               SLP_SUSPEND: code = C_BLINK;
               default:     code = C_OFF;
            endcase
         end
      end else begin : g_suspend
         always_comb begin
            if (sleep_state_e'(state) == SLP_SUSPEND)
               code = C_ON;
            else
               code = C_OFF;
         end
      end
   endgenerate

endmodule

// File: rtl/dual_led_blinker.sv
`timescale 1ns/1ps
module dual_led_blinker
   import dlb_pkg::*;
#(
   parameter int CODE_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wr,
   input  logic [7:0]            cfg_wdata,
   input  logic [1:0]            sleep_state,
   input  logic                  half_sec_tick,
   output logic [1:0]            led_level,
   output logic [1:0]            led_oe
);

   localparam int NUM_RATES = (2**(CODE_W-1)) - 1;
   localparam int PH_W      = NUM_RATES;
   localparam int SUS_LSB   = 0;
   localparam int PWR_LSB   = 4;
   localparam int SEL_BIT   = CFG_W - 1;

   generate
      if (CODE_W != 3) begin : g_bad_code
         $error("dual_led_blinker: byte layout needs 3-bit codes");
      end
   endgenerate

   logic              sel_sw;
   logic [CODE_W-1:0] pwr_code_q;
   logic [CODE_W-1:0] sus_code_q;
   logic              cfg_bit3_unused;
   logic [PH_W-1:0]   phase;
   logic [CODE_W-1:0] sw_code [LED_CNT];
   logic [CODE_W-1:0] hw_code [LED_CNT];
   logic [CODE_W-1:0] eff_code [LED_CNT];

   assign cfg_bit3_unused = cfg_wdata[3];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_sw     <= 1'b0;
         pwr_code_q <= '0;
         sus_code_q <= '0;
      end else if (cfg_wr) begin
         sel_sw     <= cfg_wdata[SEL_BIT];
         pwr_code_q <= cfg_wdata[PWR_LSB +: CODE_W];
         sus_code_q <= cfg_wdata[SUS_LSB +: CODE_W];
      end
   end

   dlb_phase_gen #(.PH_W(PH_W)) i_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (half_sec_tick),
      .phase (phase)
   );

   assign sw_code[LED_PWR] = pwr_code_q;
   assign sw_code[LED_SUS] = sus_code_q;

   generate
      for (genvar i = 0; i < LED_CNT; i++) begin : g_led
         dlb_hw_policy #(.CODE_W(CODE_W), .IS_POWER(i == LED_PWR)) i_policy (
            .state (sleep_state),
            .code  (hw_code[i])
         );

         assign eff_code[i] = sel_sw ? sw_code[i] : hw_code[i];

         dlb_code_decode #(.CODE_W(CODE_W), .PH_W(PH_W)) i_decode (
            .code  (eff_code[i]),
            .phase (phase),
            .level (led_level[i])
         );

         assign led_oe[i] = ~led_level[i];
      end
   endgenerate

   AST_SW_LOW_SINKS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_sw && pwr_code_q == '0) |-> (!led_level[LED_PWR] && led_oe[LED_PWR])); // R2
   AST_SW_RELEASE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_sw && sus_code_q == '1) |-> (led_level[LED_SUS] && !led_oe[LED_SUS])); // R3
   AST_HW_PWR_ON_IN_S0: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_sw && sleep_state == SLP_ON) |-> !led_level[LED_PWR]); // R7
   AST_HW_SUS_TRACKS_S3: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_sw |-> (led_level[LED_SUS] == (sleep_state != SLP_SUSPEND))); // R8
   AST_SAME_CODE_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_sw && pwr_code_q == sus_code_q) |-> (led_level[LED_PWR] == led_level[LED_SUS])); // R9

endmodule

// File: tb/test_dual_led_blinker.sv
`timescale 1ns/1ps
module test_dual_led_blinker;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [1:0] sleep_state = 2'b00;
   logic       half_sec_tick = 1'b0;
   logic [1:0] led_level;
   logic [1:0] led_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [3:0] q_exp [$];
   string      q_tag [$];

   // bench-side model of the requirements
   logic [7:0] m_cfg = 8'h00;
   logic [1:0] m_state = 2'b00;
   int         m_tc = 0;

   always #10 clk = ~clk;

   dual_led_blinker i_dual_led_blinker (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_wr        (cfg_wr),
      .cfg_wdata     (cfg_wdata),
      .sleep_state   (sleep_state),
      .half_sec_tick (half_sec_tick),
      .led_level     (led_level),
      .led_oe        (led_oe)
   );

   function automatic logic code_level(input logic [2:0] c, input int tc);
      case (c)
         3'b111:  return 1'b1;              // R3
         3'b110:  return tc[0];             // R4
         3'b101:  return tc[1];             // R5
         3'b100:  return tc[2];             // R5
         default: return 1'b0;              // R2
      endcase
   endfunction

   function automatic logic [3:0] expected();
      logic [2:0] pc, sc;
      logic       pl, sl;
      if (m_cfg[7]) begin                   // R6
         pc = m_cfg[6:4];
         sc = m_cfg[2:0];
      end else begin                        // R7, R8
         pc = (m_state == 2'b00) ? 3'b000 : (m_state == 2'b01) ? 3'b110 : 3'b111;
         sc = (m_state == 2'b01) ? 3'b000 : 3'b111;
      end
      pl = code_level(pc, m_tc);
      sl = code_level(sc, m_tc);
      return {pl, sl, ~pl, ~sl};            // R11
   endfunction

   task automatic step(input logic tick, input logic wr, input logic [7:0] wd,
                       input logic [1:0] st, input string tag);
      @(negedge clk);
      half_sec_tick = tick;
      cfg_wr        = wr;
      cfg_wdata     = wd;
      sleep_state   = st;
      if (wr) m_cfg = wd;
      m_state = st;
      if (tick) m_tc++;
      q_exp.push_back(expected());
      q_tag.push_back(tag);
   endtask

   // monitor: compares results a quarter period after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (q_exp.size() > 0) begin
            logic [3:0] e;
            string      t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if ({led_level, led_oe} !== e) begin
               errors++;
               $display("FAIL %s: {level,oe} got %b expected %b", t, {led_level, led_oe}, e);
            end
         end
      end
   end

   initial begin
      #(64'd200000 * 20);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(0, 0, 8'h00, 2'b00, "R1 reset state");
      step(0, 0, 8'h00, 2'b01, "R7 R8 S3 entry");
      for (int k = 0; k < 4; k++) step(1, 0, 8'h00, 2'b01, "R7 S3 power blink");
      step(0, 0, 8'h00, 2'b10, "R7 R8 S5");
      step(0, 0, 8'h00, 2'b11, "R7 R8 S5 alt");
      step(0, 0, 8'h00, 2'b00, "R7 S0");
      step(0, 1, 8'hF0, 2'b00, "R6 R3 R2 sw release/low");
      step(0, 1, 8'h81, 2'b00, "R2 code 001");
      step(0, 1, 8'hA2, 2'b00, "R2 code 010");
      step(0, 1, 8'h83, 2'b00, "R2 code 011");
      step(0, 1, 8'hF7, 2'b00, "R3 both released");
      step(0, 1, 8'hEE, 2'b00, "R10 R9 1 Hz both");
      for (int k = 0; k < 5; k++) step(1, 0, 8'h00, 2'b00, "R4 R9 1 Hz ticks");
      step(0, 1, 8'hE6, 2'b00, "R10 bit3 cleared");
      step(1, 0, 8'h00, 2'b00, "R4 tick after rewrite");
      step(0, 1, 8'hD4, 2'b00, "R5 half and quarter Hz");
      for (int k = 0; k < 9; k++) step(1, 0, 8'h00, 2'b00, "R5 slow ticks");
      step(0, 1, 8'hDD, 2'b00, "R9 R10 1/2 Hz both");
      step(1, 0, 8'h00, 2'b00, "R9 1/2 Hz tick");
      step(0, 1, 8'h8F, 2'b01, "R6 sw ignores state");
      step(0, 0, 8'h00, 2'b10, "R6 sw ignores state");
      step(0, 1, 8'h6E, 2'b10, "R6 back to hardware");
      step(1, 0, 8'h00, 2'b01, "R6 R7 hardware S3");
      @(negedge clk);
      half_sec_tick = 1'b0;
      cfg_wr = 1'b0;
      while (q_exp.size() > 0) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule